// File: doc/BRIEF.md
# Initiator-Aware Priority Address Decoder

This block takes one bus access and names the single target that serves it. The inputs are the access address, a code for the kind of initiator (processor, PCI bus master or ISA/LPC bus master), the port-space and system-management select lines, and a set of region registers that software programs. These registers hold the processor's own interrupt-controller window, the relocatable I/O APIC window, a bank of PCI windows, the top of RAM, the protected SMM RAM window with its chipset unlock bit, and the legacy video window.

The decode is purely combinational. When two regions claim the same address, a fixed priority decides which one wins, and the kind of initiator limits which targets it can reach at all. A processor can reach everything. A PCI master cannot reach any processor's local APIC. An ISA/LPC master, ISA DMA included, can reach only PCI windows and RAM. A separate flag reports an I/O APIC window that software has placed on top of RAM or on top of an enabled PCI window.

Top module: `adr_route_decoder`

## Requirements
- R1: With `acc_valid` low, every select, `pci_win` and `acc_err` are low. With `acc_valid` high, exactly one of `sel_lapic`, `sel_smram`, `sel_ioapic`, `sel_pci`, `sel_ram`, `sel_io`, `acc_err` is high.
- R2: For a processor memory access (`acc_init` = 0), the checks run in this order: local APIC, SMM RAM, I/O APIC, video window, PCI windows, RAM. An address that matches none of them raises `acc_err`.
- R3: An address inside the SMM RAM window selects `sel_smram` only for a processor access with `acc_smm` or `smram_open` high. Otherwise the address falls through to the lower checks.
- R4: Only the 4 KiB window at `lapic_base` selects the local APIC. Any other address, including one inside another processor's APIC window, is decoded as an ordinary bus access.
- R5: A PCI master (`acc_init` = 1) never selects the local APIC. It is checked in the order I/O APIC, video window, PCI windows, RAM.
- R6: An ISA/LPC master (`acc_init` = 2 or 3) never selects the local APIC or the I/O APIC. With `ioapic_base` = 0, an ISA access to address 0 selects RAM.
- R7: The 4 KiB I/O APIC window wins over RAM and over any PCI window it overlaps.
- R8: With `acc_io` high, `sel_io` is selected for every initiator whatever the region registers hold, and `io_port` equals `acc_addr[15:0]`.
- R9: An address in the video window selects RAM for a processor access with `acc_smm` high. In every other case it selects `sel_pci` with `pci_win` all zero.
- R10: PCI window i matches when `pci_en[i]` is set and `base <= addr < base + 2^szlog`, where a szlog of at least the address width covers the whole space. When several windows match, `pci_win` is the one-hot bit of the lowest index. RAM matches when `acc_addr < ram_limit`.
- R11: `cfg_overlap` is high exactly when the I/O APIC window intersects RAM (`ioapic_base < ram_limit`) or intersects any enabled PCI window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_valid | input | 1 | Access present |
| acc_addr | input | AW | Access address |
| acc_init | input | 2 | Initiator: 0 processor, 1 PCI master, 2/3 ISA/LPC master |
| acc_io | input | 1 | Port-space access |
| acc_smm | input | 1 | Processor is in system-management mode |
| smram_open | input | 1 | Chipset unlock of SMM RAM |
| lapic_base | input | AW | This processor's local APIC window base (4 KiB) |
| ioapic_base | input | AW | I/O APIC window base (4 KiB) |
| pci_base | input | NP*AW | PCI window bases, window i at bits [i*AW +: AW] |
| pci_szlog | input | NP*6 | PCI window log2 sizes, window i at bits [i*6 +: 6] |
| pci_en | input | NP | PCI window enables |
| ram_limit | input | AW | First address above RAM |
| smram_base | input | AW | SMM RAM window base |
| smram_szlog | input | 6 | SMM RAM window log2 size |
| vid_base | input | AW | Video window base |
| vid_szlog | input | 6 | Video window log2 size |
| sel_lapic | output | 1 | Local APIC selected |
| sel_smram | output | 1 | SMM RAM selected |
| sel_ioapic | output | 1 | I/O APIC selected |
| sel_pci | output | 1 | PCI or video target selected |
| pci_win | output | NP | One-hot PCI window hit (zero for the video window) |
| sel_ram | output | 1 | RAM selected |
| sel_io | output | 1 | Port space selected |
| io_port | output | 16 | Port number |
| acc_err | output | 1 | No target matched |
| cfg_overlap | output | 1 | I/O APIC window overlaps RAM or an enabled PCI window |

## Verification
The same addresses are sent from each of the three kinds of initiator. This separates the reachability rules from the priority order: one address gives the local APIC, the I/O APIC or RAM depending only on who issued it. The I/O APIC is stacked on the local APIC, on RAM at address 0 and on a PCI window, so each priority step is tested against the step below it. The system-management line and the unlock bit are toggled over the part of the video window that SMM RAM shares and over the part it does not share, which separates SMM RAM gating from video steering. PCI windows are nested, disabled and widened to the whole address space to test lowest-index selection and the size rule.

// File: rtl/adr_route_pkg.sv
package adr_route_pkg;

  localparam int SZ_W = 6;

  typedef enum logic [1:0] {
    INIT_CPU = 2'd0,
    INIT_PCI = 2'd1,
    INIT_ISA = 2'd2,
    INIT_ISA_ALT = 2'd3
  } init_t;

  // Keep-mask of a size-aligned window; sizes at or above the width give zero.
  function automatic logic [63:0] win_mask(input logic [SZ_W-1:0] szlog);
    return {64{1'b1}} << szlog;
  endfunction

  function automatic logic win_hit(input logic [63:0] addr, input logic [63:0] base,
                                   input logic [SZ_W-1:0] szlog);
    return ((addr ^ base) & win_mask(szlog)) == 64'd0;
  endfunction

  // Two aligned windows meet iff they agree above the larger of the two sizes.
  function automatic logic win_overlap(input logic [63:0] b1, input logic [SZ_W-1:0] s1,
                                       input logic [63:0] b2, input logic [SZ_W-1:0] s2);
    return ((b1 ^ b2) & win_mask(s1) & win_mask(s2)) == 64'd0;
  endfunction

endpackage

// File: rtl/adr_window_match.sv
module adr_window_match
  import adr_route_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]   addr,
  input  logic [AW-1:0]   base,
  input  logic [SZ_W-1:0] szlog,
  input  logic            en,
  output logic            hit
);
  logic [63:0] addr_x;
  logic [63:0] base_x;
  logic [63:0] mask_x;

  assign addr_x = 64'(addr);
  assign base_x = 64'(base);
  // Bits above the address width are ignored, so a huge size spans all space.
  assign mask_x = win_mask(szlog) & ((64'd1 << AW) - 64'd1);
  assign hit    = en && (((addr_x ^ base_x) & mask_x) == 64'd0);
endmodule

// File: rtl/adr_overlap_scan.sv
module adr_overlap_scan
  import adr_route_pkg::*;
#(
  parameter int AW = 32,
  parameter int NP = 2,
  parameter int APIC_LOG2 = 12
) (
  input  logic [AW-1:0]      ioapic_base,
  input  logic [NP*AW-1:0]   pci_base,
  input  logic [NP*SZ_W-1:0] pci_szlog,
  input  logic [NP-1:0]      pci_en,
  input  logic [AW-1:0]      ram_limit,
  output logic               overlap
);
  localparam logic [SZ_W-1:0] APIC_SZ = SZ_W'(APIC_LOG2);

  logic [NP-1:0] pci_clash;
  logic          ram_clash;

  for (genvar i = 0; i < NP; i++) begin : g_win
    logic [63:0] wmask;
    assign wmask = win_mask(APIC_SZ) & win_mask(pci_szlog[i*SZ_W +: SZ_W])
                   & ((64'd1 << AW) - 64'd1);
    assign pci_clash[i] = pci_en[i] &&
      (((64'(ioapic_base) ^ 64'(pci_base[i*AW +: AW])) & wmask) == 64'd0);
  end

  // RAM starts at zero, so the window meets it iff its base lies below the limit.
  assign ram_clash = ioapic_base < ram_limit;
  assign overlap   = ram_clash || (|pci_clash);
endmodule

// File: rtl/adr_route_pick.sv
module adr_route_pick
  import adr_route_pkg::*;
#(
  parameter int NP = 2
) (
  input  logic          valid,
  input  logic [1:0]    init,
  input  logic          io,
  input  logic          smm,
  input  logic          smram_open,
  input  logic          hit_lapic,
  input  logic          hit_smram,
  input  logic          hit_ioapic,
  input  logic          hit_vid,
  input  logic [NP-1:0] hit_pci,
  input  logic          hit_ram,
  output logic          sel_lapic,
  output logic          sel_smram,
  output logic          sel_ioapic,
  output logic          sel_pci,
  output logic [NP-1:0] pci_win,
  output logic          sel_ram,
  output logic          sel_io,
  output logic          err
);
  logic is_cpu;
  logic is_isa;

  always_comb begin
    is_cpu     = init_t'(init) == INIT_CPU;
    is_isa     = (init_t'(init) == INIT_ISA) || (init_t'(init) == INIT_ISA_ALT);
    sel_lapic  = 1'b0;
    sel_smram  = 1'b0;
    sel_ioapic = 1'b0;
    sel_pci    = 1'b0;
    pci_win    = '0;
    sel_ram    = 1'b0;
    sel_io     = 1'b0;
    err        = 1'b0;
    if (valid) begin
      if (io)                                          sel_io = 1'b1;
      else if (is_cpu && hit_lapic)                    sel_lapic = 1'b1;
      else if (is_cpu && hit_smram && (smm || smram_open)) sel_smram = 1'b1;
      else if (!is_isa && hit_ioapic)                  sel_ioapic = 1'b1;
      else if (hit_vid) begin
        if (is_cpu && smm) sel_ram = 1'b1;
        else               sel_pci = 1'b1;
      end else if (|hit_pci) begin
        sel_pci = 1'b1;
        pci_win = hit_pci & (~hit_pci + NP'(1));
      end else if (hit_ram)                            sel_ram = 1'b1;
      else                                             err = 1'b1;
    end

    p_one_target_r1: assert (valid
        ? $onehot({sel_lapic, sel_smram, sel_ioapic, sel_pci, sel_ram, sel_io, err})
        : ({sel_lapic, sel_smram, sel_ioapic, sel_pci, sel_ram, sel_io, err, pci_win} == '0))
      else $error("route select is not one-hot");
    p_smram_gate_r3: assert (!sel_smram || (hit_smram && is_cpu && (smm || smram_open)))
      else $error("SMM RAM reached without unlock");
    p_no_lapic_r5: assert (!sel_lapic || is_cpu)
      else $error("bus master reached the local APIC");
    p_isa_reach_r6: assert (!is_isa || !(sel_ioapic || sel_lapic))
      else $error("ISA master reached an APIC");
    p_pci_win_r10: assert ($onehot0(pci_win) && ((pci_win & ~hit_pci) == '0)
                           && (sel_pci || (pci_win == '0)))
      else $error("PCI window select inconsistent");
  end
endmodule

// File: rtl/adr_route_decoder.sv
module adr_route_decoder
  import adr_route_pkg::*;
#(
  parameter int AW = 32,
  parameter int NP = 2,
  parameter int APIC_LOG2 = 12,
  parameter int PORT_W = 16
) (
  input  logic               acc_valid,
  input  logic [AW-1:0]      acc_addr,
  input  logic [1:0]         acc_init,
  input  logic               acc_io,
  input  logic               acc_smm,
  input  logic               smram_open,
  input  logic [AW-1:0]      lapic_base,
  input  logic [AW-1:0]      ioapic_base,
  input  logic [NP*AW-1:0]   pci_base,
  input  logic [NP*SZ_W-1:0] pci_szlog,
  input  logic [NP-1:0]      pci_en,
  input  logic [AW-1:0]      ram_limit,
  input  logic [AW-1:0]      smram_base,
  input  logic [SZ_W-1:0]    smram_szlog,
  input  logic [AW-1:0]      vid_base,
  input  logic [SZ_W-1:0]    vid_szlog,
  output logic               sel_lapic,
  output logic               sel_smram,
  output logic               sel_ioapic,
  output logic               sel_pci,
  output logic [NP-1:0]      pci_win,
  output logic               sel_ram,
  output logic               sel_io,
  output logic [PORT_W-1:0]  io_port,
  output logic               acc_err,
  output logic               cfg_overlap
);
  localparam logic [SZ_W-1:0] APIC_SZ = SZ_W'(APIC_LOG2);

  logic          hit_lapic;
  logic          hit_ioapic;
  logic          hit_smram;
  logic          hit_vid;
  logic [NP-1:0] hit_pci;
  logic          hit_ram;

  adr_window_match #(.AW(AW)) u_lapic (
    .addr(acc_addr), .base(lapic_base), .szlog(APIC_SZ), .en(1'b1), .hit(hit_lapic));
  adr_window_match #(.AW(AW)) u_ioapic (
    .addr(acc_addr), .base(ioapic_base), .szlog(APIC_SZ), .en(1'b1), .hit(hit_ioapic));
  adr_window_match #(.AW(AW)) u_smram (
    .addr(acc_addr), .base(smram_base), .szlog(smram_szlog), .en(1'b1), .hit(hit_smram));
  adr_window_match #(.AW(AW)) u_vid (
    .addr(acc_addr), .base(vid_base), .szlog(vid_szlog), .en(1'b1), .hit(hit_vid));

  for (genvar i = 0; i < NP; i++) begin : g_pci
    adr_window_match #(.AW(AW)) u_win (
      .addr (acc_addr),
      .base (pci_base[i*AW +: AW]),
      .szlog(pci_szlog[i*SZ_W +: SZ_W]),
      .en   (pci_en[i]),
      .hit  (hit_pci[i]));
  end

  assign hit_ram = acc_addr < ram_limit;
  assign io_port = acc_valid && acc_io ? acc_addr[PORT_W-1:0] : '0;

  adr_route_pick #(.NP(NP)) u_pick (
    .valid(acc_valid), .init(acc_init), .io(acc_io), .smm(acc_smm),
    .smram_open(smram_open), .hit_lapic(hit_lapic), .hit_smram(hit_smram),
    .hit_ioapic(hit_ioapic), .hit_vid(hit_vid), .hit_pci(hit_pci), .hit_ram(hit_ram),
    .sel_lapic(sel_lapic), .sel_smram(sel_smram), .sel_ioapic(sel_ioapic),
    .sel_pci(sel_pci), .pci_win(pci_win), .sel_ram(sel_ram), .sel_io(sel_io),
    .err(acc_err));

  adr_overlap_scan #(.AW(AW), .NP(NP), .APIC_LOG2(APIC_LOG2)) u_scan (
    .ioapic_base(ioapic_base), .pci_base(pci_base), .pci_szlog(pci_szlog),
    .pci_en(pci_en), .ram_limit(ram_limit), .overlap(cfg_overlap));
endmodule

// File: tb/adr_route_decoder_test.sv
`timescale 1ns/1ps
module adr_route_decoder_test;
  localparam int AW = 32;
  localparam int NP = 2;
  localparam int SW = 6;

  // Expected route code: {lapic, smram, ioapic, pci, ram, io, err}
  localparam logic [6:0] E_NONE = 7'b0000000;
  localparam logic [6:0] E_LAP  = 7'b1000000;
  localparam logic [6:0] E_SMR  = 7'b0100000;
  localparam logic [6:0] E_IOA  = 7'b0010000;
  localparam logic [6:0] E_PCI  = 7'b0001000;
  localparam logic [6:0] E_RAM  = 7'b0000100;
  localparam logic [6:0] E_IO   = 7'b0000010;
  localparam logic [6:0] E_ERR  = 7'b0000001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic               acc_valid, acc_io, acc_smm, smram_open;
  logic [AW-1:0]      acc_addr, lapic_base, ioapic_base, ram_limit, smram_base, vid_base;
  logic [1:0]         acc_init;
  logic [NP*AW-1:0]   pci_base;
  logic [NP*SW-1:0]   pci_szlog;
  logic [NP-1:0]      pci_en;
  logic [SW-1:0]      smram_szlog, vid_szlog;
  logic sel_lapic, sel_smram, sel_ioapic, sel_pci, sel_ram, sel_io, acc_err, cfg_overlap;
  logic [NP-1:0]      pci_win;
  logic [15:0]        io_port;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  adr_route_decoder #(.AW(AW), .NP(NP)) uut (
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_init(acc_init), .acc_io(acc_io),
    .acc_smm(acc_smm), .smram_open(smram_open), .lapic_base(lapic_base),
    .ioapic_base(ioapic_base), .pci_base(pci_base), .pci_szlog(pci_szlog),
    .pci_en(pci_en), .ram_limit(ram_limit), .smram_base(smram_base),
    .smram_szlog(smram_szlog), .vid_base(vid_base), .vid_szlog(vid_szlog),
    .sel_lapic(sel_lapic), .sel_smram(sel_smram), .sel_ioapic(sel_ioapic),
    .sel_pci(sel_pci), .pci_win(pci_win), .sel_ram(sel_ram), .sel_io(sel_io),
    .io_port(io_port), .acc_err(acc_err), .cfg_overlap(cfg_overlap));

  task automatic set_defaults();
    acc_valid   = 1'b0; acc_io = 1'b0; acc_smm = 1'b0; smram_open = 1'b0;
    acc_addr    = '0;   acc_init = 2'd0;
    lapic_base  = 32'hFEE0_0000;
    ioapic_base = 32'hFEC0_0000;
    ram_limit   = 32'h0800_0000;
    smram_base  = 32'h000A_0000; smram_szlog = 6'd16;
    vid_base    = 32'h000A_0000; vid_szlog   = 6'd17;
    pci_base    = {32'hE080_0000, 32'hE000_0000};
    pci_szlog   = {6'd20, 6'd24};
    pci_en      = 2'b11;
  endtask

  task automatic access(input logic [1:0] who, input logic [AW-1:0] a,
                        input logic io, input logic smm);
    @(negedge clk);
    acc_valid = 1'b1; acc_init = who; acc_addr = a; acc_io = io; acc_smm = smm;
    #1;
  endtask

  task automatic expect_route(input string req, input logic [6:0] exp,
                              input logic [NP-1:0] exp_win);
    logic [6:0] act;
    act = {sel_lapic, sel_smram, sel_ioapic, sel_pci, sel_ram, sel_io, acc_err};
    checks++;
    if (act !== exp || pci_win !== exp_win) begin
      fails++;
      $display("FAIL %s addr=%h init=%0d: route=%b win=%b expected route=%b win=%b",
               req, acc_addr, acc_init, act, pci_win, exp, exp_win);
    end
  endtask

  task automatic expect_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic t_idle_r1();
    set_defaults();
    @(negedge clk); acc_addr = 32'h0000_1000; #1;
    expect_route("R1 idle", E_NONE, 2'b00);
    expect_bit("R1 idle port", io_port == 16'd0, 1'b1);
  endtask

  task automatic t_cpu_order_r2_r4();
    set_defaults();
    access(2'd0, 32'hFEE0_0300, 0, 0); expect_route("R4 own window", E_LAP, 2'b00);
    access(2'd0, 32'hFEE0_1300, 0, 0); expect_route("R4 next window", E_ERR, 2'b00);
    access(2'd0, 32'h0000_1000, 0, 0); expect_route("R2 ram", E_RAM, 2'b00);
    access(2'd0, 32'h0900_0000, 0, 0); expect_route("R2 unmatched", E_ERR, 2'b00);
    access(2'd0, 32'hFEC0_0010, 0, 0); expect_route("R2 ioapic", E_IOA, 2'b00);
    lapic_base = 32'h0010_0000;
    access(2'd0, 32'h0010_0020, 0, 0); expect_route("R4 moved apic", E_LAP, 2'b00);
    access(2'd0, 32'h0010_1000, 0, 0); expect_route("R4 other cpu area", E_RAM, 2'b00);
  endtask

  task automatic t_stack_r5_r6();
    set_defaults();
    lapic_base = 32'h0010_0000; ioapic_base = 32'h0010_0000;
    access(2'd0, 32'h0010_0040, 0, 0); expect_route("R2 lapic over ioapic", E_LAP, 2'b00);
    access(2'd1, 32'h0010_0040, 0, 0); expect_route("R5 pci master", E_IOA, 2'b00);
    access(2'd2, 32'h0010_0040, 0, 0); expect_route("R6 isa master", E_RAM, 2'b00);
    access(2'd3, 32'h0010_0040, 0, 0); expect_route("R6 isa code3", E_RAM, 2'b00);
    set_defaults();
    access(2'd1, 32'hFEE0_0010, 0, 0); expect_route("R5 no lapic", E_ERR, 2'b00);
    access(2'd2, 32'hFEC0_0010, 0, 0); expect_route("R6 no ioapic", E_ERR, 2'b00);
  endtask

  task automatic t_ioapic_shadow_r7_r6();
    set_defaults();
    ioapic_base = 32'h0000_0000;
    access(2'd0, 32'h0000_0000, 0, 0); expect_route("R7 over ram", E_IOA, 2'b00);
    access(2'd2, 32'h0000_0000, 0, 0); expect_route("R6 isa dma addr0", E_RAM, 2'b00);
    ioapic_base = 32'hE000_0000;
    access(2'd1, 32'hE000_0004, 0, 0); expect_route("R7 over pci", E_IOA, 2'b00);
    access(2'd2, 32'hE000_0004, 0, 0); expect_route("R6 isa pci", E_PCI, 2'b01);
  endtask

  task automatic t_smm_r3_r9();
    set_defaults();
    access(2'd0, 32'h000A_0100, 0, 0); expect_route("R3 closed", E_PCI, 2'b00);
    access(2'd0, 32'h000A_0100, 0, 1); expect_route("R3 smm", E_SMR, 2'b00);
    smram_open = 1'b1;
    access(2'd0, 32'h000A_0100, 0, 0); expect_route("R3 unlocked", E_SMR, 2'b00);
    access(2'd1, 32'h000A_0100, 0, 1); expect_route("R3 pci master", E_PCI, 2'b00);
    smram_open = 1'b0;
    access(2'd0, 32'h000B_0000, 0, 1); expect_route("R9 smm video", E_RAM, 2'b00);
    access(2'd0, 32'h000B_0000, 0, 0); expect_route("R9 video", E_PCI, 2'b00);
    access(2'd2, 32'h000B_0000, 0, 1); expect_route("R9 isa video", E_PCI, 2'b00);
  endtask

  task automatic t_ports_r8();
    set_defaults();
    access(2'd0, 32'hFEE0_0080, 1, 0); expect_route("R8 cpu port", E_IO, 2'b00);
    expect_bit("R8 port number", io_port == 16'h0080, 1'b1);
    access(2'd2, 32'h1234_03F8, 1, 1); expect_route("R8 isa port", E_IO, 2'b00);
    expect_bit("R8 port number isa", io_port == 16'h03F8, 1'b1);
  endtask

  task automatic t_windows_r10();
    set_defaults();
    access(2'd0, 32'hE080_0010, 0, 0); expect_route("R10 lowest index", E_PCI, 2'b01);
    access(2'd0, 32'hE090_0010, 0, 0); expect_route("R10 only outer", E_PCI, 2'b01);
    pci_en = 2'b10;
    access(2'd0, 32'hE080_0010, 0, 0); expect_route("R10 win0 off", E_PCI, 2'b10);
    access(2'd0, 32'hE000_0010, 0, 0); expect_route("R10 disabled", E_ERR, 2'b00);
    pci_szlog = {6'd32, 6'd24};
    access(2'd1, 32'h0000_0010, 0, 0); expect_route("R10 whole space", E_PCI, 2'b10);
    set_defaults();
    access(2'd0, 32'h07FF_FFFF, 0, 0); expect_route("R10 ram top", E_RAM, 2'b00);
    access(2'd0, 32'h0800_0000, 0, 0); expect_route("R10 ram limit", E_ERR, 2'b00);
  endtask

  task automatic t_overlap_r11();
    set_defaults(); #1;
    expect_bit("R11 clean map", cfg_overlap, 1'b0);
    ioapic_base = 32'h0000_0000; #1;
    expect_bit("R11 over ram", cfg_overlap, 1'b1);
    ioapic_base = 32'hE08F_F000; #1;
    expect_bit("R11 over pci", cfg_overlap, 1'b1);
    pci_en = 2'b00; #1;
    expect_bit("R11 disabled windows", cfg_overlap, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    set_defaults();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle_r1();
    t_cpu_order_r2_r4();
    t_stack_r5_r6();
    t_ioapic_shadow_r7_r6();
    t_smm_r3_r9();
    t_ports_r8();
    t_windows_r10();
    t_overlap_r11();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule